// File: doc/BRIEF.md
# NAND Command and Address Cycle Sequencer

This block turns one bus request into the exact string of latch cycles a raw NAND flash device expects on its command/address interface. A request carries an opcode, an optional column, an optional row and three mode bits (large or small page, 16-bit or 8-bit bus, three or two row bytes). From these the block works out, at acceptance, every byte that must go out. That list may hold a pointer command, the main command, the column bytes, the row bytes and a trailing confirm command. It then plays the bytes out one per write-enable pulse, with CLE or ALE marking each one as a command or an address byte.

The sequence adds the rules a flash device imposes. On small pages, a sequential-input (program load) opcode first gets a pointer command that selects the half-page or spare area the column falls in, and the column is rebased into that area. On large pages, a spare-area read is rewritten as a normal read of the column past the page end. A read that carries an address gets its start command appended. A random data output request gets its start command appended and is followed by a settle gap. On a 16-bit bus the column is counted in words, except for opcodes that only ever move bytes. Waiting on ready/busy and moving page data belong to other blocks.

The control is one state machine with states IDLE, SETUP, PULSE, HOLD, GAP and DONE. IDLE goes to SETUP when a request is accepted, or to DONE if the request needs no bytes. SETUP goes to PULSE after WE_HIGH_CYC cycles. PULSE goes to SETUP for the next byte, or to HOLD after the last byte, once WE_LOW_CYC cycles have passed. HOLD goes to GAP if a settle gap is due, and otherwise to DONE, after WE_HIGH_CYC cycles. GAP goes to DONE after its computed length. DONE always returns to IDLE one cycle later.

Top module: `nand_cmd_seq`

## Requirements
- R1: `req_ready` is high only in IDLE. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_valid` while busy is ignored and changes nothing on the pins.
- R2: In reset and in IDLE the pins rest at `nand_ce_n`=1, `nand_we_n`=1, `nand_cle`=0, `nand_ale`=0, `nand_io`=0, `seq_done`=0, and `req_ready`=1.
- R3: A command byte is presented with CLE=1 and ALE=0, and an address byte with ALE=1 and CLE=0. Each byte is shown for WE_HIGH_CYC cycles with WE high, then for WE_LOW_CYC cycles with WE low. The last byte is held WE_HIGH_CYC more cycles with WE high. `nand_ce_n` is low from the first setup cycle to the end of the hold or gap.
- R4: Bytes go out in this order: pointer command, main command, column bytes, row bytes, trailing command. The first cycle after acceptance is the first byte's setup.
- R5: Small page, opcode 0x80. If column ≥ SP_PAGE, the pointer is 0x50 and the column is reduced by SP_PAGE. If column < 256, the pointer is 0x00. Otherwise the pointer is 0x01 and the column is reduced by 256.
- R6: A small page sends one column byte (bits 7:0). A large page sends two column bytes, bits 7:0 then bits 15:8. The byte-only opcodes 0x90, 0xEC, 0xEE and 0xEF send only the low column byte.
- R7: With the 16-bit bus bit set, the column, after any R5/R9 adjustment, is shifted right one place before sending, except for the byte-only opcodes of R6.
- R8: A row sends bits 7:0 then bits 15:8. With the three-row bit set, bits 23:16 follow.
- R9: Large page, opcode 0x50, sends command 0x00 with the column increased by LP_PAGE. A column byte pair is always sent.
- R10: Large page, opcode 0x00 with a column or a row, ends with command 0x30. Without either, it ends after the 0x00 cycle.
- R11: Large page, opcode 0x05, ends with command 0xE0, then a gap of ceil(T/CLK_NS) cycles with CE low, CLE/ALE low and WE high. T is TCCS_NS, or 500 ns when TCCS_NS is 0.
- R12: `nand_io[15:8]` is 0x00 on every command and address cycle. The byte value is on `nand_io[7:0]`.
- R13: With `req_no_cmd` set there is no command, pointer or trailing cycle, but the address bytes are still sent. A request with no bytes at all gives only the DONE cycle.
- R14: `seq_done` is high for exactly one cycle, right after the final hold or gap, with `nand_ce_n` high. `req_ready` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this edge if valid |
| req_opcode | input | 8 | Main command opcode |
| req_no_cmd | input | 1 | Skip all command cycles, send addresses only |
| req_has_col | input | 1 | Column present |
| req_col | input | COL_W | Column address in bytes |
| req_has_row | input | 1 | Row present |
| req_row | input | ROW_W | Row (page) address |
| req_large_page | input | 1 | 1 = large-page rules, 0 = small-page rules |
| req_bus16 | input | 1 | Device has a 16-bit data bus |
| req_row3 | input | 1 | Send a third row byte |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable strobe, active low |
| nand_io | output | 16 | Data/command/address bus |
| seq_done | output | 1 | One-cycle completion pulse |

## Verification
A wrong state or a wrong byte index shows up on the pins in the same cycle. A wrong state gives the wrong CLE/ALE type, the wrong byte on `nand_io`, or a WE edge one cycle early or late. A wrong byte index gives a repeated or skipped byte. A wrong plan, such as a bad pointer choice, a missing column halving or a missing start command, shows on the first cycle of the byte concerned. A gap counter that is off by one moves `seq_done` by a cycle. So the bench compares every pin against a cycle-accurate model on every clock, and each fault is caught within one cycle of the point where it first changes a pin.

// File: rtl/nand_seq_pkg.sv
`timescale 1ns/1ps
package nand_seq_pkg;

    localparam logic [7:0] OP_READ0       = 8'h00;
    localparam logic [7:0] OP_READ1       = 8'h01;
    localparam logic [7:0] OP_RNDOUT      = 8'h05;
    localparam logic [7:0] OP_READSTART   = 8'h30;
    localparam logic [7:0] OP_READOOB     = 8'h50;
    localparam logic [7:0] OP_SEQIN       = 8'h80;
    localparam logic [7:0] OP_READID      = 8'h90;
    localparam logic [7:0] OP_RNDOUTSTART = 8'hE0;
    localparam logic [7:0] OP_PARAM       = 8'hEC;
    localparam logic [7:0] OP_GETFEAT     = 8'hEE;
    localparam logic [7:0] OP_SETFEAT     = 8'hEF;

    // pointer + main + 2 column + 3 row + trailing
    localparam int MAX_SLOTS = 8;
    localparam int SLOT_IW   = $clog2(MAX_SLOTS);
    localparam int SLOT_CW   = $clog2(MAX_SLOTS + 1);

    typedef struct packed {
        logic       is_cmd;
        logic [7:0] val;
    } bus_slot_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_GAP,
        ST_DONE
    } seq_state_t;

    function automatic logic op_is_narrow(input logic [7:0] op);
        return (op == OP_READID) || (op == OP_PARAM) ||
               (op == OP_GETFEAT) || (op == OP_SETFEAT);
    endfunction

endpackage

// File: rtl/nand_seq_plan.sv
`timescale 1ns/1ps
module nand_seq_plan
    import nand_seq_pkg::*;
#(
    parameter int SP_PAGE = 512,
    parameter int LP_PAGE = 2048,
    parameter int COL_W   = 16,
    parameter int ROW_W   = 24
) (
    input  logic [7:0]                      opcode,
    input  logic                            no_cmd,
    input  logic                            has_col,
    input  logic [COL_W-1:0]                col,
    input  logic                            has_row,
    input  logic [ROW_W-1:0]                row,
    input  logic                            large_page,
    input  logic                            bus16,
    input  logic                            row3,
    output bus_slot_t [MAX_SLOTS-1:0]       slots,
    output logic [SLOT_CW-1:0]              count,
    output logic                            need_gap
);

    logic [7:0]       op_eff;
    logic [COL_W-1:0] col_eff;
    logic             col_on;
    logic             narrow;
    logic [SLOT_CW-1:0] n;

    always_comb begin
        slots    = '0;
        need_gap = 1'b0;
        n        = '0;
        op_eff   = opcode;
        col_eff  = col;
        col_on   = has_col;

        // large page: spare read becomes a read past the page end
        if (large_page && !no_cmd && opcode == OP_READOOB) begin
            op_eff  = OP_READ0;
            col_eff = col + COL_W'(LP_PAGE);
            col_on  = 1'b1;
        end

        // small page: pointer command ahead of program load
        if (!large_page && !no_cmd && opcode == OP_SEQIN) begin
            if (col >= COL_W'(SP_PAGE)) begin
                slots[n[SLOT_IW-1:0]] = '{is_cmd: 1'b1, val: OP_READOOB};
                col_eff = col - COL_W'(SP_PAGE);
            end else if (col < COL_W'(256)) begin
                slots[n[SLOT_IW-1:0]] = '{is_cmd: 1'b1, val: OP_READ0};
            end else begin
                slots[n[SLOT_IW-1:0]] = '{is_cmd: 1'b1, val: OP_READ1};
                col_eff = col - COL_W'(256);
            end
            n = n + 1'b1;
        end

        if (!no_cmd) begin
            slots[n[SLOT_IW-1:0]] = '{is_cmd: 1'b1, val: op_eff};
            n = n + 1'b1;
        end

        narrow = op_is_narrow(op_eff);

        if (col_on) begin
            if (bus16 && !narrow)
                col_eff = col_eff >> 1;
            slots[n[SLOT_IW-1:0]] = '{is_cmd: 1'b0, val: col_eff[7:0]};
            n = n + 1'b1;
            if (large_page && !narrow) begin
                slots[n[SLOT_IW-1:0]] = '{is_cmd: 1'b0, val: col_eff[15:8]};
                n = n + 1'b1;
            end
        end

        if (has_row) begin
            slots[n[SLOT_IW-1:0]] = '{is_cmd: 1'b0, val: row[7:0]};
            n = n + 1'b1;
            slots[n[SLOT_IW-1:0]] = '{is_cmd: 1'b0, val: row[15:8]};
            n = n + 1'b1;
            if (row3) begin
                slots[n[SLOT_IW-1:0]] = '{is_cmd: 1'b0, val: row[23:16]};
                n = n + 1'b1;
            end
        end

        if (large_page && !no_cmd) begin
            if (op_eff == OP_READ0 && (col_on || has_row)) begin
                slots[n[SLOT_IW-1:0]] = '{is_cmd: 1'b1, val: OP_READSTART};
                n = n + 1'b1;
            end else if (op_eff == OP_RNDOUT) begin
                slots[n[SLOT_IW-1:0]] = '{is_cmd: 1'b1, val: OP_RNDOUTSTART};
                n = n + 1'b1;
                need_gap = 1'b1;
            end
        end

        count = n;
    end

endmodule

// File: rtl/nand_seq_timer.sv
`timescale 1ns/1ps
module nand_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/nand_cmd_seq.sv
`timescale 1ns/1ps
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int SP_PAGE     = 512,
    parameter int LP_PAGE     = 2048,
    parameter int COL_W       = 16,
    parameter int ROW_W       = 24,
    parameter int WE_LOW_CYC  = 2,
    parameter int WE_HIGH_CYC = 2,
    parameter int CLK_NS      = 8,
    parameter int TCCS_NS     = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [7:0]       req_opcode,
    input  logic             req_no_cmd,
    input  logic             req_has_col,
    input  logic [COL_W-1:0] req_col,
    input  logic             req_has_row,
    input  logic [ROW_W-1:0] req_row,
    input  logic             req_large_page,
    input  logic             req_bus16,
    input  logic             req_row3,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic [15:0]      nand_io,
    output logic             seq_done
);

    localparam int GAP_NS   = (TCCS_NS > 0) ? TCCS_NS : 500;
    localparam int GAP_RAW  = (GAP_NS + CLK_NS - 1) / CLK_NS;
    localparam int GAP_CYC  = (GAP_RAW < 1) ? 1 : GAP_RAW;
    localparam int T_MAX0   = (WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC;
    localparam int T_MAX    = (T_MAX0 > GAP_CYC) ? T_MAX0 : GAP_CYC;
    localparam int CNT_W    = $clog2(T_MAX + 1);
    localparam logic [CNT_W-1:0] LD_LOW  = CNT_W'(WE_LOW_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HIGH = CNT_W'(WE_HIGH_CYC - 1);
    localparam logic [CNT_W-1:0] LD_GAP  = CNT_W'(GAP_CYC - 1);

    bus_slot_t [MAX_SLOTS-1:0] plan_slots;
    logic [SLOT_CW-1:0]        plan_count;
    logic                      plan_gap;

    nand_seq_plan #(
        .SP_PAGE (SP_PAGE),
        .LP_PAGE (LP_PAGE),
        .COL_W   (COL_W),
        .ROW_W   (ROW_W)
    ) i_plan (
        .opcode     (req_opcode),
        .no_cmd     (req_no_cmd),
        .has_col    (req_has_col),
        .col        (req_col),
        .has_row    (req_has_row),
        .row        (req_row),
        .large_page (req_large_page),
        .bus16      (req_bus16),
        .row3       (req_row3),
        .slots      (plan_slots),
        .count      (plan_count),
        .need_gap   (plan_gap)
    );

    seq_state_t                state_q, state_d;
    bus_slot_t [MAX_SLOTS-1:0] slots_q;
    logic [SLOT_CW-1:0]        count_q;
    logic [SLOT_IW-1:0]        idx_q;
    logic                      gap_q;
    logic                      tmr_load;
    logic [CNT_W-1:0]          tmr_val;
    logic                      tmr_expired;
    logic                      last_slot;
    logic                      accept;
    bus_slot_t                 cur;

    nand_seq_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign last_slot = ({1'b0, idx_q} == (count_q - 1'b1));
    assign cur       = slots_q[idx_q];

    // next state and phase timer
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (plan_count == '0) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d  = ST_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = LD_HIGH;
                    end
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    state_d  = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_LOW;
                end
            end
            ST_PULSE: begin
                if (tmr_expired) begin
                    state_d  = last_slot ? ST_HOLD : ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HIGH;
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    if (gap_q) begin
                        state_d  = ST_GAP;
                        tmr_load = 1'b1;
                        tmr_val  = LD_GAP;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_expired)
                    state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and captured plan
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slots_q <= '0;
            count_q <= '0;
            idx_q   <= '0;
            gap_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                slots_q <= plan_slots;
                count_q <= plan_count;
                gap_q   <= plan_gap;
                idx_q   <= '0;
            end else if (state_q == ST_PULSE && tmr_expired && !last_slot) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // pin decode
    always_comb begin
        req_ready = 1'b0;
        seq_done  = 1'b0;
        nand_ce_n = 1'b1;
        nand_cle  = 1'b0;
        nand_ale  = 1'b0;
        nand_we_n = 1'b1;
        nand_io   = 16'h0000;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_SETUP, ST_HOLD, ST_PULSE: begin
                nand_ce_n = 1'b0;
                nand_cle  = cur.is_cmd;
                nand_ale  = !cur.is_cmd;
                nand_io   = {8'h00, cur.val};
                nand_we_n = (state_q != ST_PULSE);
            end
            ST_GAP:  nand_ce_n = 1'b0;
            ST_DONE: seq_done  = 1'b1;
            default: req_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/nand_seq_chk.sv
`timescale 1ns/1ps
module nand_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        nand_ce_n,
    input logic        nand_cle,
    input logic        nand_ale,
    input logic        nand_we_n,
    input logic [15:0] nand_io,
    input logic        seq_done
);

    a_r3_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    a_r3_ce_during_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_cle || nand_ale) |-> !nand_ce_n);

    a_r3_strobe_has_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> (nand_cle || nand_ale));

    a_r3_bus_steady_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && !$past(nand_we_n)) |-> ($stable(nand_io) && $stable(nand_cle)));

    a_r12_upper_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_cle || nand_ale) |-> (nand_io[15:8] == 8'h00));

    a_r14_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    a_r14_done_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> req_ready);

    a_r14_ce_released_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> nand_ce_n);

    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r2_idle_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (nand_ce_n && nand_we_n && !seq_done && !nand_cle && !nand_ale));

endmodule

bind nand_cmd_seq nand_seq_chk i_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .nand_ce_n (nand_ce_n),
    .nand_cle  (nand_cle),
    .nand_ale  (nand_ale),
    .nand_we_n (nand_we_n),
    .nand_io   (nand_io),
    .seq_done  (seq_done)
);

// File: tb/test_nand_cmd_seq.sv
`timescale 1ns/1ps
module test_nand_cmd_seq;

    localparam int SP   = 512;
    localparam int LP   = 2048;
    localparam int WL   = 2;
    localparam int WH   = 2;
    localparam int CKNS = 8;
    localparam int GAPC = (500 + CKNS - 1) / CKNS;

    typedef struct packed {
        logic        ready;
        logic        done;
        logic        ce_n;
        logic        cle;
        logic        ale;
        logic        we_n;
        logic [15:0] io;
    } pins_t;

    localparam pins_t IDLE_PINS = '{ready: 1'b1, done: 1'b0, ce_n: 1'b1, cle: 1'b0,
                                    ale: 1'b0, we_n: 1'b1, io: 16'h0000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_opcode = '0;
    logic        req_no_cmd = 1'b0;
    logic        req_has_col = 1'b0;
    logic [15:0] req_col = '0;
    logic        req_has_row = 1'b0;
    logic [23:0] req_row = '0;
    logic        req_large_page = 1'b0;
    logic        req_bus16 = 1'b0;
    logic        req_row3 = 1'b0;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, seq_done;
    logic [15:0] nand_io;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag   = "R2";
    pins_t exp_q[$];

    always #4 clk = ~clk;

    nand_cmd_seq #(
        .SP_PAGE(SP), .LP_PAGE(LP), .COL_W(16), .ROW_W(24),
        .WE_LOW_CYC(WL), .WE_HIGH_CYC(WH), .CLK_NS(CKNS), .TCCS_NS(0)
    ) i_nand_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_opcode(req_opcode), .req_no_cmd(req_no_cmd), .req_has_col(req_has_col),
        .req_col(req_col), .req_has_row(req_has_row), .req_row(req_row),
        .req_large_page(req_large_page), .req_bus16(req_bus16), .req_row3(req_row3),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_io(nand_io), .seq_done(seq_done)
    );

    task automatic tick();
        pins_t act, e;
        @(negedge clk);
        act = '{ready: req_ready, done: seq_done, ce_n: nand_ce_n, cle: nand_cle,
                ale: nand_ale, we_n: nand_we_n, io: nand_io};
        e = (exp_q.size() > 0) ? exp_q.pop_front() : IDLE_PINS;
        n_cmp++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, e);
        end
    endtask

    // behavioural expectation built from the requirements
    task automatic model(input int op_in, input bit nc, input bit hc, input int col_in,
                         input bit hr, input int row, input bit lp, input bit b16, input bit r3);
        int  q[$];
        int  op = op_in;
        int  c  = col_in;
        bit  colp = hc;
        bit  narrow;
        bit  gap = 0;
        pins_t p;
        if (lp && !nc && op == 'h50) begin op = 0; c = c + LP; colp = 1; end      // R9
        if (!lp && !nc && op == 'h80) begin                                        // R5
            if (c >= SP)       begin q.push_back('h150); c = c - SP;  end
            else if (c < 256)  q.push_back('h100);
            else               begin q.push_back('h101); c = c - 256; end
        end
        if (!nc) q.push_back('h100 + op);                                          // R13
        narrow = (op == 'h90) || (op == 'hEC) || (op == 'hEE) || (op == 'hEF);
        if (colp) begin                                                            // R6 R7
            if (b16 && !narrow) c = c >> 1;
            q.push_back(c & 'hFF);
            if (lp && !narrow) q.push_back((c >> 8) & 'hFF);
        end
        if (hr) begin                                                              // R8
            q.push_back(row & 'hFF);
            q.push_back((row >> 8) & 'hFF);
            if (r3) q.push_back((row >> 16) & 'hFF);
        end
        if (lp && !nc) begin
            if (op == 0 && (colp || hr)) q.push_back('h130);                       // R10
            else if (op == 5) begin q.push_back('h1E0); gap = 1; end               // R11
        end
        p = '{ready: 1'b0, done: 1'b0, ce_n: 1'b0, cle: 1'b0, ale: 1'b0, we_n: 1'b1, io: 16'h0};
        foreach (q[i]) begin                                                       // R3 R4 R12
            p.cle = q[i][8];
            p.ale = !q[i][8];
            p.io  = {8'h00, 8'(q[i])};
            p.we_n = 1'b1;
            for (int k = 0; k < WH; k++) exp_q.push_back(p);
            p.we_n = 1'b0;
            for (int k = 0; k < WL; k++) exp_q.push_back(p);
        end
        if (q.size() > 0) begin
            p.we_n = 1'b1;
            for (int k = 0; k < WH; k++) exp_q.push_back(p);
        end
        if (gap) begin
            p = '{ready: 1'b0, done: 1'b0, ce_n: 1'b0, cle: 1'b0, ale: 1'b0, we_n: 1'b1, io: 16'h0};
            for (int k = 0; k < GAPC; k++) exp_q.push_back(p);
        end
        p = '{ready: 1'b0, done: 1'b1, ce_n: 1'b1, cle: 1'b0, ale: 1'b0, we_n: 1'b1, io: 16'h0};
        exp_q.push_back(p);                                                        // R14
    endtask

    task automatic send(input string t, input int op, input bit nc, input bit hc, input int col,
                        input bit hr, input int row, input bit lp, input bit b16, input bit r3,
                        input bit noise);
        tick();
        tag = t;
        req_opcode = 8'(op); req_no_cmd = nc; req_has_col = hc; req_col = 16'(col);
        req_has_row = hr; req_row = 24'(row); req_large_page = lp; req_bus16 = b16;
        req_row3 = r3; req_valid = 1'b1;
        model(op, nc, hc, col, hr, row, lp, b16, r3);
        tick();
        req_valid = 1'b0;
        while (exp_q.size() > 0) begin
            if (noise && exp_q.size() > 3) begin                                   // R1
                req_valid = 1'b1; req_opcode = 8'h90; req_no_cmd = 1'b0;
                req_has_col = 1'b1; req_col = 16'h00AA; req_large_page = !lp;
            end else begin
                req_valid = 1'b0;
            end
            tick();
        end
        req_valid = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tag = "R2 reset";
        repeat (3) tick();
        rst_n = 1'b1;
        repeat (2) tick();

        send("R5 R4 sp seqin low col",      'h80, 0, 1, 'h10,  1, 'h1234,   0, 0, 0, 0);
        send("R5 sp seqin upper half",      'h80, 0, 1, 300,   1, 'h0042,   0, 0, 0, 0);
        send("R5 R8 sp seqin spare row3",   'h80, 0, 1, 520,   1, 'h5A1234, 0, 0, 1, 0);
        send("R7 R5 sp bus16 seqin",        'h80, 0, 1, 300,   0, 0,        0, 1, 0, 0);
        send("R6 sp read one col byte",     'h00, 0, 1, 'hC3,  1, 'h0102,   0, 0, 0, 0);
        send("R10 R6 lp read0 addr",        'h00, 0, 1, 'h123, 1, 'h4567,   1, 0, 0, 0);
        send("R10 lp read0 bare",           'h00, 0, 0, 0,     0, 0,        1, 0, 0, 0);
        send("R9 lp oob read",              'h50, 0, 1, 'h10,  1, 'h0203,   1, 0, 0, 0);
        send("R11 lp rndout gap",           'h05, 0, 1, 'h40,  0, 0,        1, 0, 0, 0);
        send("R7 lp bus16 read0",           'h00, 0, 1, 'h200, 1, 'h0011,   1, 1, 0, 0);
        send("R6 R7 lp bus16 readid narrow",'h90, 0, 1, 'h20,  0, 0,        1, 1, 0, 0);
        send("R8 lp row3 read0",            'h00, 0, 1, 'h7FF, 1, 'hABCDEF, 1, 0, 1, 0);
        send("R13 no cmd row only",         'h80, 1, 0, 0,     1, 'h0F0E,   1, 0, 0, 0);
        send("R13 empty request",           'h00, 1, 0, 0,     0, 0,        1, 0, 0, 0);
        send("R1 busy ignores valid",       'h00, 0, 1, 'h055, 1, 'h6677,   1, 0, 1, 1);
        send("R3 R14 lp erase style",       'h60, 0, 0, 0,     1, 'h0800,   1, 0, 0, 0);
        tag = "R1 R2 idle after";
        repeat (3) tick();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule